// File: doc/BRIEF.md
# Occupancy Wrap Reset Sequencer

This block brings a ring's stale occupancy count in a downstream DMA engine back to zero when the ring is torn down. That count cannot be written directly. It only moves when doorbell writes add to it. The sequencer therefore adds exactly enough doorbell increments to carry a 21-bit counter through its wrap point. For occupancy `N`, that total is `2^22 - N`. Each doorbell write can carry only a small count, so the total is spread over many capped writes.

A controller pulses `start_i` and supplies the known occupancy, the ring's configured mode and a quirk-enable input. An occupancy of zero means the value is not known, and the block fetches it over a read request/acknowledge pair. When the quirk path is taken, the order is:

1. a ring-reset request;
2. a request to switch the ring to plain ring mode (mode code 0), unless the ring is already in that mode;
3. the doorbell writes, over a valid/ready port;
4. a request to restore the original mode, unless the ring is already in plain ring mode;
5. a final ring reset, which also clears the ring's local state.

Every request waits for its acknowledge before the next step begins. A one-cycle done pulse closes the sequence.

The controller is one state machine:

- States: `S_IDLE`, `S_READ_OCC`, `S_PRE_RST`, `S_TO_RING`, `S_DOORBELL`, `S_RESTORE`, `S_FINAL_RST`, `S_DONE`.
- Transitions out of `S_IDLE` on start:
  - quirk low: to `S_FINAL_RST`;
  - quirk high, occupancy zero: to `S_READ_OCC`;
  - otherwise: to `S_PRE_RST`.
- `S_READ_OCC` on acknowledge: to `S_FINAL_RST` if the value read is zero, else to `S_PRE_RST`.
- `S_PRE_RST` on acknowledge: to `S_TO_RING` for a non-plain mode, else to `S_DOORBELL`.
- `S_TO_RING` on acknowledge: to `S_DOORBELL`.
- `S_DOORBELL` on the accepted last chunk: to `S_RESTORE` for a non-plain mode, else to `S_FINAL_RST`.
- `S_RESTORE` on acknowledge: to `S_FINAL_RST`.
- `S_FINAL_RST` on acknowledge: to `S_DONE`.
- `S_DONE`: always back to `S_IDLE`.

Top module: `occ_wrap_seq`

## Requirements
- R1: With `quirk_en_i` low at start, the only activity is one final ring reset (`reset_final_o`=1), followed by done. No read, mode request or doorbell write occurs.
- R2: With the quirk high and `occ_i` zero at start, the block raises `occ_rd_req_o`. The value returned on `occ_rd_data_i` is the occupancy used for the rest of the sequence.
- R3: If the fetched occupancy is zero, no pre-reset, mode request or doorbell follows. The final ring reset and done come directly.
- R4: For a nonzero occupancy the steps come in this order: pre-reset (`reset_final_o`=0), switch to plain mode, doorbell writes, restore mode, final reset (`reset_final_o`=1).
- R5: The doorbell counts accepted in one sequence sum to exactly 2^22 minus the occupancy used.
- R6: Each accepted doorbell carries 127 while more than 127 remain, and otherwise the whole remainder. A count is never zero and never above 127. Count and valid hold steady while `db_ready_i` is low.
- R7: A mode request carries 0 (plain ring) for the switch and the mode latched at start for the restore. Both requests are skipped when that mode is 0.
- R8: The final ring reset occurs on every path, including the quirk-off and zero-occupancy paths.
- R9: Every request stays high until acknowledged, and no two of read, reset, mode and doorbell requests are active together.
- R10: `done_o` is high for exactly one cycle, the cycle after the final reset is acknowledged.
- R11: A `start_i` pulse while a sequence is running has no effect. The running sequence completes unchanged, with one done, and no second sequence follows.
- R12: After reset all request, valid and done outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start strobe, taken only when idle |
| occ_i | input | OCC_W | Known occupancy, 0 means fetch it |
| quirk_en_i | input | 1 | Enables the doorbell wrap sequence |
| mode_i | input | MODE_W | Ring's configured mode, 0 = plain ring |
| occ_rd_req_o | output | 1 | Occupancy read request |
| occ_rd_ack_i | input | 1 | Occupancy read acknowledge |
| occ_rd_data_i | input | OCC_W | Occupancy value returned with the acknowledge |
| reset_req_o | output | 1 | Ring reset request |
| reset_final_o | output | 1 | Marks the reset as the final one, which also clears local state |
| reset_ack_i | input | 1 | Ring reset acknowledge |
| mode_req_o | output | 1 | Mode reconfigure request |
| mode_sel_o | output | MODE_W | Mode to apply |
| mode_ack_i | input | 1 | Mode reconfigure acknowledge |
| db_valid_o | output | 1 | Doorbell write valid |
| db_count_o | output | DB_W | Doorbell increment |
| db_ready_i | input | 1 | Doorbell write ready |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench drives these corner cases:

- **Largest 21-bit occupancy.** The wrap leaves a final chunk of 2. A chunker that rounds to full chunks would overshoot the wrap total.
- **Remainder of exactly 127.** A design with an off-by-one in its last-chunk test would emit a spurious zero-count write, or end one chunk early.
- **Fetched occupancy, non-plain mode, ready stalls.** Wrong ordering or a dropped restore shows up as an out-of-order event. Because a start pulse arrives mid-run, a design that re-latches its inputs on that pulse would restore the wrong mode or start a second run.
- **Zero fetch and quirk-off paths.** A design that skips the final reset, or runs doorbells for zero occupancy, is caught here.

// File: rtl/owr_pkg.sv
package owr_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_READ_OCC,
        S_PRE_RST,
        S_TO_RING,
        S_DOORBELL,
        S_RESTORE,
        S_FINAL_RST,
        S_DONE
    } owr_state_t;

endpackage

// File: rtl/owr_remain_ctr.sv
module owr_remain_ctr #(
    parameter int OCC_W     = 21,
    parameter int DB_W      = 7,
    parameter int CHUNK_MAX = 127
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             load_i,
    input  logic [OCC_W-1:0] occ_i,
    input  logic             take_i,
    output logic [DB_W-1:0]  chunk_o,
    output logic             last_o
);
    localparam int REM_W = OCC_W + 2;
    localparam logic [REM_W-1:0] WRAP_TOTAL = REM_W'(1) << (OCC_W + 1);
    localparam logic [REM_W-1:0] CAP_R      = REM_W'(CHUNK_MAX);
    localparam logic [DB_W-1:0]  CAP_D      = DB_W'(CHUNK_MAX);

    logic [REM_W-1:0] rem_q;
    logic [REM_W-1:0] chunk_w;

    assign last_o  = (rem_q <= CAP_R);
    assign chunk_o = last_o ? rem_q[DB_W-1:0] : CAP_D;
    assign chunk_w = {{(REM_W-DB_W){1'b0}}, chunk_o};

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)
            rem_q <= '0;
        else if (load_i)
            rem_q <= WRAP_TOTAL - {2'b00, occ_i};
        else if (take_i)
            rem_q <= rem_q - chunk_w;
    end

    // R5: the last accepted chunk leaves nothing behind
    p_sum_exact_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (take_i && last_o && !load_i) |=> (rem_q == '0));

    // R6: a full chunk is taken only while more than the cap remains
    p_full_chunk_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (take_i && !last_o && !load_i) |=> (rem_q == $past(rem_q) - CAP_R));

endmodule

// File: rtl/owr_fsm.sv
module owr_fsm
    import owr_pkg::*;
#(
    parameter int MODE_W = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              start_i,
    input  logic              quirk_i,
    input  logic              occ_zero_i,
    input  logic [MODE_W-1:0] mode_i,
    input  logic              rd_ack_i,
    input  logic              rd_zero_i,
    input  logic              rst_ack_i,
    input  logic              mode_ack_i,
    input  logic              db_ready_i,
    input  logic              last_i,
    output logic              rd_req_o,
    output logic              rst_req_o,
    output logic              rst_final_o,
    output logic              mode_req_o,
    output logic [MODE_W-1:0] mode_sel_o,
    output logic              db_valid_o,
    output logic              load_o,
    output logic              load_rd_o,
    output logic              done_o
);
    localparam logic [MODE_W-1:0] PLAIN = '0;

    owr_state_t        state_q, state_d;
    logic [MODE_W-1:0] mode_q;
    logic              plain_w;

    assign plain_w = (mode_q == PLAIN);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= S_IDLE;
            mode_q  <= PLAIN;
        end else begin
            state_q <= state_d;
            if (state_q == S_IDLE && start_i)
                mode_q <= mode_i;
        end
    end

    always_comb begin
        state_d   = state_q;
        load_o    = 1'b0;
        load_rd_o = 1'b0;
        unique case (state_q)
            S_IDLE: if (start_i) begin
                if (!quirk_i)
                    state_d = S_FINAL_RST;
                else if (occ_zero_i)
                    state_d = S_READ_OCC;
                else begin
                    state_d = S_PRE_RST;
                    load_o  = 1'b1;
                end
            end
            S_READ_OCC: if (rd_ack_i) begin
                if (rd_zero_i)
                    state_d = S_FINAL_RST;
                else begin
                    state_d   = S_PRE_RST;
                    load_o    = 1'b1;
                    load_rd_o = 1'b1;
                end
            end
            S_PRE_RST:   if (rst_ack_i)  state_d = plain_w ? S_DOORBELL : S_TO_RING;
            S_TO_RING:   if (mode_ack_i) state_d = S_DOORBELL;
            S_DOORBELL:  if (db_ready_i && last_i)
                             state_d = plain_w ? S_FINAL_RST : S_RESTORE;
            S_RESTORE:   if (mode_ack_i) state_d = S_FINAL_RST;
            S_FINAL_RST: if (rst_ack_i)  state_d = S_DONE;
            S_DONE:      state_d = S_IDLE;
            default:     state_d = S_IDLE;
        endcase
    end

    always_comb begin
        rd_req_o    = 1'b0;
        rst_req_o   = 1'b0;
        rst_final_o = 1'b0;
        mode_req_o  = 1'b0;
        mode_sel_o  = PLAIN;
        db_valid_o  = 1'b0;
        done_o      = 1'b0;
        unique case (state_q)
            S_IDLE:      ;
            S_READ_OCC:  rd_req_o = 1'b1;
            S_PRE_RST:   rst_req_o = 1'b1;
            S_TO_RING:   mode_req_o = 1'b1;
            S_DOORBELL:  db_valid_o = 1'b1;
            S_RESTORE: begin
                mode_req_o = 1'b1;
                mode_sel_o = mode_q;
            end
            S_FINAL_RST: begin
                rst_req_o   = 1'b1;
                rst_final_o = 1'b1;
            end
            S_DONE:      done_o = 1'b1;
            default:     ;
        endcase
    end

    // R9: at most one request class active
    p_one_req_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0({rd_req_o, rst_req_o, mode_req_o, db_valid_o}));

    // R9: reset and mode requests wait for their acknowledge
    p_rst_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rst_req_o && !rst_ack_i) |=> (rst_req_o && $stable(rst_final_o)));
    p_mode_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_req_o && !mode_ack_i) |=> (mode_req_o && $stable(mode_sel_o)));

    // R10: done is a single-cycle pulse
    p_done_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    // R7: no mode request is made for a ring already in plain mode
    p_plain_skip_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mode_req_o |-> !plain_w);

    // R11: a start during a running sequence leaves the latched mode alone
    p_ignore_start_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start_i && state_q != S_IDLE) |=> $stable(mode_q));

endmodule

// File: rtl/occ_wrap_seq.sv
module occ_wrap_seq #(
    parameter int OCC_W     = 21,
    parameter int MODE_W    = 2,
    parameter int DB_W      = 7,
    parameter int CHUNK_MAX = 127
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              start_i,
    input  logic [OCC_W-1:0]  occ_i,
    input  logic              quirk_en_i,
    input  logic [MODE_W-1:0] mode_i,
    output logic              occ_rd_req_o,
    input  logic              occ_rd_ack_i,
    input  logic [OCC_W-1:0]  occ_rd_data_i,
    output logic              reset_req_o,
    output logic              reset_final_o,
    input  logic              reset_ack_i,
    output logic              mode_req_o,
    output logic [MODE_W-1:0] mode_sel_o,
    input  logic              mode_ack_i,
    output logic              db_valid_o,
    output logic [DB_W-1:0]   db_count_o,
    input  logic              db_ready_i,
    output logic              done_o
);
    localparam logic [DB_W-1:0] CAP_D = DB_W'(CHUNK_MAX);

    logic             load_w, load_rd_w, last_w, take_w;
    logic [OCC_W-1:0] load_val_w;

    assign take_w     = db_valid_o && db_ready_i;
    assign load_val_w = load_rd_w ? occ_rd_data_i : occ_i;

    owr_fsm #(.MODE_W(MODE_W)) u_fsm (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .start_i     (start_i),
        .quirk_i     (quirk_en_i),
        .occ_zero_i  (occ_i == '0),
        .mode_i      (mode_i),
        .rd_ack_i    (occ_rd_ack_i),
        .rd_zero_i   (occ_rd_data_i == '0),
        .rst_ack_i   (reset_ack_i),
        .mode_ack_i  (mode_ack_i),
        .db_ready_i  (db_ready_i),
        .last_i      (last_w),
        .rd_req_o    (occ_rd_req_o),
        .rst_req_o   (reset_req_o),
        .rst_final_o (reset_final_o),
        .mode_req_o  (mode_req_o),
        .mode_sel_o  (mode_sel_o),
        .db_valid_o  (db_valid_o),
        .load_o      (load_w),
        .load_rd_o   (load_rd_w),
        .done_o      (done_o)
    );

    owr_remain_ctr #(
        .OCC_W     (OCC_W),
        .DB_W      (DB_W),
        .CHUNK_MAX (CHUNK_MAX)
    ) u_ctr (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .load_i  (load_w),
        .occ_i   (load_val_w),
        .take_i  (take_w),
        .chunk_o (db_count_o),
        .last_o  (last_w)
    );

    // R6: doorbell count is in 1..cap
    p_chunk_range_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        db_valid_o |-> (db_count_o != '0 && db_count_o <= CAP_D));

    // R6: a stalled doorbell keeps valid and count
    p_db_stall_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (db_valid_o && !db_ready_i) |=> (db_valid_o && $stable(db_count_o)));

    // R2: occupancy read request waits for its acknowledge
    p_rd_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (occ_rd_req_o && !occ_rd_ack_i) |=> occ_rd_req_o);

endmodule

// File: tb/occ_wrap_seq_test.sv
module occ_wrap_seq_test;
    localparam int OCC_W = 21;
    localparam int MODE_W = 2;
    localparam int DB_W = 7;
    localparam int WRAP = 1 << 22;
    localparam int LIMIT = 190000;

    localparam int EV_READ = 1, EV_PRE = 2, EV_MODE = 3, EV_DB = 4, EV_FIN = 5, EV_DONE = 6;

    logic clk = 1'b0, rst_n = 1'b0;
    logic start = 1'b0, quirk = 1'b0;
    logic [OCC_W-1:0] occ = '0, rd_data = '0;
    logic [MODE_W-1:0] mode = '0;
    logic rd_ack = 1'b0, rst_ack = 1'b0, mode_ack = 1'b0, db_ready = 1'b0;
    logic rd_req, rst_req, rst_fin, mode_req, db_valid, done;
    logic [MODE_W-1:0] mode_sel;
    logic [DB_W-1:0] db_count;

    int vectors = 0, miscompares = 0, cycles = 0;
    int ack_dly = 0, ack_cnt = 0;
    bit stall_en = 0, prev_done = 0;
    int exp_kind[$];
    int exp_val[$];

    always #5 clk = ~clk;

    occ_wrap_seq uut (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .occ_i(occ),
        .quirk_en_i(quirk), .mode_i(mode),
        .occ_rd_req_o(rd_req), .occ_rd_ack_i(rd_ack), .occ_rd_data_i(rd_data),
        .reset_req_o(rst_req), .reset_final_o(rst_fin), .reset_ack_i(rst_ack),
        .mode_req_o(mode_req), .mode_sel_o(mode_sel), .mode_ack_i(mode_ack),
        .db_valid_o(db_valid), .db_count_o(db_count), .db_ready_i(db_ready),
        .done_o(done)
    );

    function automatic string req_of(int k);
        case (k)
            EV_READ: return "R2";
            EV_PRE:  return "R4";
            EV_MODE: return "R7";
            EV_DB:   return "R6";
            EV_FIN:  return "R8";
            default: return "R10";
        endcase
    endfunction

    function automatic void fail(string r, string what, int act, int expv);
        miscompares++;
        $display("FAIL %s %s: actual %0d expected %0d", r, what, act, expv);
    endfunction

    function automatic void observe(int kind, int val);
        vectors++;
        if (exp_kind.size() == 0) begin
            fail("R11", "unexpected event kind", kind, 0);
            return;
        end
        if (exp_kind[0] != kind) begin
            fail("R4", "event order kind", kind, exp_kind[0]);
            return;
        end
        if (kind == EV_DB) begin
            int want;
            want = (exp_val[0] > 127) ? 127 : exp_val[0];
            if (val != want) fail("R6", "doorbell count", val, want);
            exp_val[0] -= val;
            if (exp_val[0] <= 0) begin
                if (exp_val[0] < 0) fail("R5", "doorbell sum overshoot", exp_val[0], 0);
                void'(exp_kind.pop_front());
                void'(exp_val.pop_front());
            end
        end else begin
            if (val != exp_val[0]) fail(req_of(kind), "event value", val, exp_val[0]);
            void'(exp_kind.pop_front());
            void'(exp_val.pop_front());
        end
    endfunction

    function automatic void push(int k, int v);
        exp_kind.push_back(k);
        exp_val.push_back(v);
    endfunction

    // responder and per-clock comparison, all on the falling edge
    initial begin
        forever begin
            @(negedge clk);
            cycles++;
            if (cycles > LIMIT) begin
                fail("R9", "watchdog expired, cycles", cycles, LIMIT);
                $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
                $finish;
            end
            if (rst_n) begin
                // R12/R11: with nothing expected the outputs stay quiet
                if (exp_kind.size() == 0) begin
                    vectors++;
                    if (rd_req || rst_req || mode_req || db_valid || done)
                        fail("R11", "activity while idle",
                             {rd_req, rst_req, mode_req, db_valid, done}, 0);
                end
                if (done && prev_done) fail("R10", "done longer than one cycle", 2, 1);
                if (done) observe(EV_DONE, 1);
                prev_done = done;

                db_ready = stall_en ? ((cycles % 4) != 0) : 1'b1;
                if (db_valid && db_ready) observe(EV_DB, int'(db_count));

                if (rd_ack || rst_ack || mode_ack) begin
                    rd_ack = 0; rst_ack = 0; mode_ack = 0; ack_cnt = 0;
                end else if (rd_req || rst_req || mode_req) begin
                    if (ack_cnt >= ack_dly) begin
                        if (rd_req) begin
                            rd_ack = 1; observe(EV_READ, 1);
                        end else if (rst_req) begin
                            rst_ack = 1; observe(rst_fin ? EV_FIN : EV_PRE, 1);
                        end else begin
                            mode_ack = 1; observe(EV_MODE, int'(mode_sel));
                        end
                    end else ack_cnt++;
                end
            end
        end
    end

    task automatic run_seq(input int glitch_at);
        @(negedge clk);
        start = 1;
        @(negedge clk);
        start = 0;
        if (glitch_at > 0) begin
            repeat (glitch_at) @(negedge clk);
            mode = 2'd0; occ = 21'd5; quirk = 1'b0;
            start = 1;
            @(negedge clk);
            start = 0;
        end
        while (exp_kind.size() != 0) @(negedge clk);
        repeat (6) @(negedge clk);
    endtask

    initial begin
        // R12: reset state
        repeat (3) @(negedge clk);
        vectors++;
        if (rd_req || rst_req || mode_req || db_valid || done)
            fail("R12", "outputs during reset", {rd_req, rst_req, mode_req, db_valid, done}, 0);
        rst_n = 1;
        repeat (3) @(negedge clk);
        vectors++;
        if (rd_req || rst_req || mode_req || db_valid || done)
            fail("R12", "outputs after reset", {rd_req, rst_req, mode_req, db_valid, done}, 0);

        // R1/R8: quirk off, non-plain mode, nonzero occupancy
        quirk = 0; mode = 2'd2; occ = 21'd77; ack_dly = 2;
        push(EV_FIN, 1); push(EV_DONE, 1);
        run_seq(0);

        // R4/R5/R6: largest occupancy, plain mode, final chunk of 2
        quirk = 1; mode = 2'd0; occ = 21'd2097151; ack_dly = 0;
        push(EV_PRE, 1); push(EV_DB, WRAP - 2097151); push(EV_FIN, 1); push(EV_DONE, 1);
        run_seq(0);

        // R2/R7/R11: fetched occupancy, remainder exactly 127, stalls, start mid-run
        quirk = 1; mode = 2'd3; occ = '0; rd_data = 21'd2096899; ack_dly = 3; stall_en = 1;
        push(EV_READ, 1); push(EV_PRE, 1); push(EV_MODE, 0);
        push(EV_DB, WRAP - 2096899); push(EV_MODE, 3); push(EV_FIN, 1); push(EV_DONE, 1);
        run_seq(3000);
        stall_en = 0;

        // R3: fetched occupancy of zero
        quirk = 1; mode = 2'd1; occ = '0; rd_data = '0; ack_dly = 1;
        push(EV_READ, 1); push(EV_FIN, 1); push(EV_DONE, 1);
        run_seq(0);

        // R4/R5/R7: known occupancy, mode 1
        quirk = 1; mode = 2'd1; occ = 21'd2000000; ack_dly = 0;
        push(EV_PRE, 1); push(EV_MODE, 0); push(EV_DB, WRAP - 2000000);
        push(EV_MODE, 1); push(EV_FIN, 1); push(EV_DONE, 1);
        run_seq(0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule